// File: doc/BRIEF.md
# Thermal Sensor Control and Status Registers

This block sits between a simple 32-bit register bus and an on-chip temperature sensor with its converter. Software puts the sensor into normal mode by setting two enable bits. The block then waits out a fixed settle interval and only after that allows a conversion request to take effect. Once conversions are running, the block issues a conversion pulse at a fixed period. It captures each 12-bit code the sensor returns and keeps the most recent one in a readable result register. Two read-only trim words, driven from input ports, give software the calibration data that goes with the sensor.

All timing is counted in ticks. A tick is a fixed number of system clock cycles, and that number is a parameter. The tick prescaler restarts whenever normal mode is entered, so the settle interval is exact. The bus uses byte offsets that are word aligned. The two low address bits are ignored. Writes take effect on the clock edge where `reg_we` is sampled high, and read data follows `reg_addr` combinationally.

Codes from the sensor arrive on a valid/ready port. `samp_ready` is high only while conversions are running. A code is taken on a cycle where `samp_valid` and `samp_ready` are both high. While ready is low the source may keep `samp_valid` up or drop it, and the block ignores it either way.

Top module: `tsense_ctl`

## Requirements
- R1: After reset, every readable register at offsets 0x00, 0x04, 0x0C and 0x10 reads 0, and `conv_go` and `samp_ready` are low.
- R2: Offset 0x00 is the mode register. Bit 0 enables the sensor and bit 1 enables the converter. Both bits are read/write, bits 31:2 read 0, and normal mode means both bits are 1.
- R3: Offset 0x04 bit 0 is the start request. A write to it is accepted only while normal mode holds after the write, and a write to the mode register that leaves normal mode clears the request.
- R4: Conversions never run earlier than SETTLE_TICKS*TICK_DIV clock edges after the edge that entered normal mode. A request made earlier is held pending and takes effect on exactly that edge.
- R5: Offset 0x10 bit 0 reads 1 exactly when normal mode holds, the settle interval is complete and the start request is set. The other bits read 0.
- R6: While conversions are running, `conv_go` pulses for one cycle on each tick boundary (the cycle whose tick counter reaches TICK_DIV-1, counted from normal-mode entry). The first pulse comes on the first such boundary at or after the run starts, and the pulses repeat every PERIOD_TICKS*TICK_DIV cycles.
- R7: `samp_ready` equals the running flag. The code on `samp_code` is captured on an edge where `samp_valid` and `samp_ready` are both high, and offset 0x0C returns it in bits 11:0 with zeros above. At every other edge the result register holds its value.
- R8: Clearing either enable bit stops conversions on the writing edge. Running, ready and the start request all read 0 afterwards, and the next run requires a full new settle interval.
- R9: Offsets 0x18 and 0x1C are trim words 0 and 1. Each reads its valid input in bit 31 and its 12-bit trim code in bits 11:0, with zeros elsewhere.
- R10: Writes to offsets 0x0C, 0x10, 0x18 and 0x1C, and to unmapped offsets, change nothing. Reads of unmapped offsets return 0.
- R11: Writing 0 to the start request while running stops conversions on that edge. Writing 1 again once settled restarts them on the next edge, with no new settle interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register (low two bits ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| trim_valid | input | TRIM_N | Valid flag of each trim word |
| trim_code | input | TRIM_N*12 | Trim codes, word 0 in the low 12 bits |
| conv_go | output | 1 | One-cycle conversion request to the sensor |
| samp_valid | input | 1 | Sensor code valid |
| samp_ready | output | 1 | Block accepts a code (conversions running) |
| samp_code | input | 12 | Sensor code |

## Verification
The bench sweeps the delay between entering normal mode and writing the start request across the whole settle window and a few cycles past it. For each delay it checks the exact edge on which running begins and the cycles of the first two conversion pulses. A design that counted the settle interval from the start write, or let an early request through, would show running on the wrong edge. A prescaler left free-running across mode changes would shift every pulse. The bench also drops an enable bit in the middle of a run and checks that the block then waits a full new settle interval, not a partial one. It offers codes while ready is low, writes to every read-only offset, and reads unmapped offsets, so that a leaking capture, a writable status bit or a stray decode would show up as a changed read value.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int unsigned CODE_W = 12;
  // word indices (byte offset / 4)
  localparam int unsigned IDX_MODE   = 0;
  localparam int unsigned IDX_START  = 1;
  localparam int unsigned IDX_RESULT = 3;
  localparam int unsigned IDX_STATUS = 4;
  localparam int unsigned IDX_TRIM0  = 6;
  localparam logic [1:0]  MODE_NORMAL = 2'b11;
endpackage

// File: rtl/tsense_tick.sv
module tsense_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = en;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      assign tick = en && (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!en)     cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
  parameter int unsigned SETTLE_TICKS = 60,
  parameter int unsigned PERIOD_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic normal,
  input  logic start_on,
  input  logic tick,
  output logic settled,
  output logic run,
  output logic conv_go
);
  localparam int unsigned SW = $clog2(SETTLE_TICKS + 1);
  localparam int unsigned PW = $clog2(PERIOD_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);

  logic [SW-1:0] settle_q;
  logic [PW-1:0] phase_q;

  assign run     = normal && settled && start_on;
  assign conv_go = run && tick && (phase_q == P_LAST);

  // settle interval: counted in ticks from normal-mode entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      settled  <= 1'b0;
    end else if (!normal) begin
      settle_q <= '0;
      settled  <= 1'b0;
    end else if (tick && !settled) begin
      if (settle_q == SW'(SETTLE_TICKS - 1)) settled <= 1'b1;
      else                                   settle_q <= settle_q + 1'b1;
    end
  end

  // period phase: parked at the last slot so the first tick of a run fires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= P_LAST;
    else if (!run)     phase_q <= P_LAST;
    else if (tick)     phase_q <= (phase_q == P_LAST) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/tsense_ctl.sv
module tsense_ctl
  import tsense_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 50,
  parameter int unsigned SETTLE_TICKS = 60,
  parameter int unsigned PERIOD_TICKS = 20,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned TRIM_N       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [TRIM_N-1:0]        trim_valid,
  input  logic [TRIM_N*CODE_W-1:0] trim_code,
  output logic                     conv_go,
  input  logic                     samp_valid,
  output logic                     samp_ready,
  input  logic [CODE_W-1:0]        samp_code
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]       widx;
  logic [1:0]          mode_q;
  logic                start_q;
  logic [CODE_W-1:0]   result_q;
  logic                normal, normal_nxt, wr_mode, wr_start;
  logic                tick, settled, run;
  logic [31:0]         trim_word [TRIM_N];
  logic                unused_bits;

  assign widx        = reg_addr[ADDR_W-1:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:2]};
  assign wr_mode     = reg_we && (widx == IW'(IDX_MODE));
  assign wr_start    = reg_we && (widx == IW'(IDX_START));
  assign normal      = (mode_q == MODE_NORMAL);
  assign normal_nxt  = wr_mode ? (reg_wdata[1:0] == MODE_NORMAL) : normal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_q <= 1'b0;
    else if (!normal_nxt) start_q <= 1'b0;
    else if (wr_start)   start_q <= reg_wdata[0];
  end

  tsense_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (normal),
    .tick (tick)
  );

  tsense_seq #(
    .SETTLE_TICKS(SETTLE_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .normal  (normal),
    .start_on(start_q),
    .tick    (tick),
    .settled (settled),
    .run     (run),
    .conv_go (conv_go)
  );

  assign samp_ready = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        result_q <= '0;
    else if (samp_valid && samp_ready) result_q <= samp_code;
  end

  generate
    for (genvar i = 0; i < TRIM_N; i++) begin : g_trim
      assign trim_word[i] = {trim_valid[i], {(31-CODE_W){1'b0}},
                             trim_code[i*CODE_W +: CODE_W]};
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (widx)
      IW'(IDX_MODE):   reg_rdata = {30'd0, mode_q};
      IW'(IDX_START):  reg_rdata = {31'd0, start_q};
      IW'(IDX_RESULT): reg_rdata = {{(32-CODE_W){1'b0}}, result_q};
      IW'(IDX_STATUS): reg_rdata = {31'd0, run};
      default: begin
        for (int i = 0; i < TRIM_N; i++)
          if (widx == IW'(IDX_TRIM0 + i)) reg_rdata = trim_word[i];
      end
    endcase
  end
endmodule

// File: rtl/tsense_ctl_chk.sv
module tsense_ctl_chk #(
  parameter int unsigned TICK_DIV     = 50,
  parameter int unsigned SETTLE_TICKS = 60,
  parameter int unsigned PERIOD_TICKS = 20,
  parameter int unsigned CODE_W       = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_q,
  input logic              start_q,
  input logic              run,
  input logic              conv_go,
  input logic              samp_valid,
  input logic              samp_ready,
  input logic [CODE_W-1:0] samp_code,
  input logic [CODE_W-1:0] result_q
);
  localparam int unsigned SD = TICK_DIV * SETTLE_TICKS;
  localparam int unsigned PD = TICK_DIV * PERIOD_TICKS;
  localparam int unsigned NW = $clog2(SD + 1);
  localparam int unsigned GW = $clog2(PD + 2);

  logic [NW-1:0] norm_cnt;
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 norm_cnt <= '0;
    else if (mode_q != 2'b11)   norm_cnt <= '0;
    else if (norm_cnt < NW'(SD)) norm_cnt <= norm_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (!run) begin
      gap <= '0; seen <= 1'b0;
    end else if (conv_go) begin
      gap <= GW'(1); seen <= 1'b1;
    end else if (gap < GW'(PD + 1)) begin
      gap <= gap + 1'b1;
    end
  end

  p_settle_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (norm_cnt >= NW'(SD)));

  p_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go && seen) |-> (gap == GW'(PD)));

  p_go_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> run);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_valid && samp_ready) |=> $stable(result_q));

  p_take_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && samp_ready) |=> (result_q == $past(samp_code)));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b11) |-> (!run && !samp_ready));

  p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b11) |-> !start_q);
endmodule

bind tsense_ctl tsense_ctl_chk #(
  .TICK_DIV    (TICK_DIV),
  .SETTLE_TICKS(SETTLE_TICKS),
  .PERIOD_TICKS(PERIOD_TICKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_q    (mode_q),
  .start_q   (start_q),
  .run       (run),
  .conv_go   (conv_go),
  .samp_valid(samp_valid),
  .samp_ready(samp_ready),
  .samp_code (samp_code),
  .result_q  (result_q)
);

// File: tb/tsense_ctl_bench.sv
`timescale 1ns/1ps
module tsense_ctl_bench;
  localparam int DIV = 3, SET = 4, PER = 3;
  localparam int SD = DIV * SET, PD = DIV * PER;
  localparam logic [7:0] A_MODE = 8'h00, A_START = 8'h04, A_RES = 8'h0C,
                         A_STAT = 8'h10, A_TRIM0 = 8'h18, A_TRIM1 = 8'h1C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  trim_valid = '0;
  logic [23:0] trim_code = '0;
  logic        conv_go, samp_valid = 1'b0, samp_ready;
  logic [11:0] samp_code = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  tsense_ctl #(.TICK_DIV(DIV), .SETTLE_TICKS(SET), .PERIOD_TICKS(PER)) u_tsense_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trim_valid(trim_valid),
    .trim_code(trim_code), .conv_go(conv_go), .samp_valid(samp_valid),
    .samp_ready(samp_ready), .samp_code(samp_code));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int e);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; e = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // polls status; returns first running cycle and first two pulse cycles
  task automatic watch(output int r_seen, output int g1, output int g2, output bit mis);
    r_seen = -1; g1 = -1; g2 = -1; mis = 0;
    reg_addr = A_STAT;
    for (int i = 0; i < 60; i++) begin
      #1;
      if (reg_rdata[0] && r_seen < 0) r_seen = cyc;
      if (samp_ready !== reg_rdata[0]) mis = 1;
      if (conv_go) begin
        if (g1 < 0) g1 = cyc; else if (g2 < 0) g2 = cyc;
      end
      @(negedge clk);
    end
  endtask

  function automatic int first_go(input int km, input int r);
    int e = km + DIV - 1;
    while (e < r) e += DIV;
    return e;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t, km, ks, rs, g1, g2, rexp, gexp;
    bit mis;
    logic [11:0] last;

    repeat (3) @(negedge clk);
    check("R1 go in reset", {31'd0, conv_go}, 0);
    check("R1 ready in reset", {31'd0, samp_ready}, 0);
    rst_n = 1'b1;
    rd(A_MODE, v);  check("R1 mode", v, 0);
    rd(A_START, v); check("R1 start", v, 0);
    rd(A_RES, v);   check("R1 result", v, 0);
    rd(A_STAT, v);  check("R1 status", v, 0);

    // R2 mode register
    wr(A_MODE, 32'hFFFF_FFFF, t); rd(A_MODE, v); check("R2 all ones", v, 3);
    wr(A_MODE, 32'h2, t);         rd(A_MODE, v); check("R2 converter only", v, 2);
    // R3 start refused outside normal mode
    wr(A_MODE, 32'h1, t); wr(A_START, 1, t);
    rd(A_START, v); check("R3 start ignored", v, 0);
    rd(A_STAT, v);  check("R3 not running", v, 0);

    // R4 R5 R6 R7: sweep start delay across the settle window
    for (int d = 0; d <= SD + 4; d++) begin
      wr(A_MODE, 0, t);
      wr(A_MODE, 3, km);
      repeat (d) @(negedge clk);
      wr(A_START, 1, ks);
      watch(rs, g1, g2, mis);
      rexp = (km + SD > ks) ? km + SD : ks;
      gexp = first_go(km, rexp);
      check($sformatf("R4 R5 run edge d=%0d", d), rs, rexp);
      check($sformatf("R7 ready tracks run d=%0d", d), {31'd0, mis}, 0);
      check($sformatf("R6 first pulse d=%0d", d), g1, gexp);
      check($sformatf("R6 second pulse d=%0d", d), g2, gexp + PD);
    end

    // R7 capture while running
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); samp_valid = 1'b1; samp_code = 12'h5A3 + 12'(k * 12'h2F1);
      last = samp_code;
      @(negedge clk); samp_valid = 1'b0;
      rd(A_RES, v); check("R7 capture", v, {20'd0, last});
    end
    samp_code = 12'h123;
    rd(A_RES, v); check("R7 hold without valid", v, {20'd0, last});

    // R11 start toggle while settled
    wr(A_START, 0, t); rd(A_STAT, v); check("R11 stop", v, 0);
    check("R11 ready low", {31'd0, samp_ready}, 0);
    wr(A_START, 1, t); rd(A_STAT, v); check("R11 restart no settle", v, 1);

    // R8 drop an enable bit mid-run
    wr(A_MODE, 1, t); #1;
    check("R8 ready low", {31'd0, samp_ready}, 0);
    rd(A_STAT, v);  check("R8 status", v, 0);
    rd(A_START, v); check("R8 start cleared", v, 0);
    @(negedge clk); samp_valid = 1'b1; samp_code = 12'hEEE;
    @(negedge clk); samp_valid = 1'b0;
    rd(A_RES, v); check("R8 R7 no capture when not ready", v, {20'd0, last});
    wr(A_MODE, 3, km); wr(A_START, 1, ks);
    watch(rs, g1, g2, mis);
    check("R8 full settle again", rs, km + SD);
    check("R8 R6 pulse after resettle", g1, first_go(km, km + SD));

    // R9 trim words
    trim_valid = 2'b01; trim_code = {12'h1F0, 12'hABC};
    rd(A_TRIM0, v); check("R9 trim0", v, 32'h8000_0ABC);
    rd(A_TRIM1, v); check("R9 trim1", v, 32'h0000_01F0);
    trim_valid = 2'b10; trim_code = {12'hFFF, 12'h001};
    rd(A_TRIM0, v); check("R9 trim0 b", v, 32'h0000_0001);
    rd(A_TRIM1, v); check("R9 trim1 b", v, 32'h8000_0FFF);

    // R10 read-only and unmapped
    wr(A_RES, 32'hFFFF_FFFF, t);  rd(A_RES, v);   check("R10 result ro", v, {20'd0, last});
    wr(A_STAT, 32'h0, t);         rd(A_STAT, v);  check("R10 status ro", v, 1);
    wr(A_TRIM0, 32'h0, t);        rd(A_TRIM0, v); check("R10 trim ro", v, 32'h0000_0001);
    wr(8'h08, 32'h0, t);          rd(A_MODE, v);  check("R10 unmapped write", v, 3);
    rd(8'h08, v); check("R10 unmapped 08", v, 0);
    rd(8'h14, v); check("R10 unmapped 14", v, 0);
    rd(8'h20, v); check("R10 unmapped 20", v, 0);
    rd(8'hFC, v); check("R10 unmapped FC", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule